// File: doc/BRIEF.md
# Shared-Converter Two-Channel Sample-Hold Sequencer

This block lets one 12-bit digital-to-analog converter serve two analog outputs. Each output has its own external sample-and-hold stage with a hold control: high means hold, low means track the converter. The block takes a pair of codes and runs a fixed schedule. It loads channel A's code while both stages hold, waits for the converter to settle, and then opens A's track window. It closes that window and then does the same for channel B. The converter code and both hold controls always change together in a single registered update, and the block drives the converter directly.

A code pair written at any time is kept in a buffer. It is applied at the start of the next schedule, so it never disturbs a channel that is tracking. Once the first schedule has run, the block repeats the schedule with the latest codes after a programmable idle time. This refreshes the held voltages even when the codes stay the same, which limits droop. The settle, track and idle durations are run-time cycle counts.

Top module: `dac_sh_mux_ctrl`

## Requirements
- R1: After reset, `hold_a_o` and `hold_b_o` are 1 and `dac_code_o` is 0. They stay that way until the first code pair is written.
- R2: One cycle after a pending write is seen in idle, a schedule starts. `dac_code_o` takes channel A's code with both holds at 1 for S cycles, where S is `settle_cyc_i`.
- R3: Channel A's track window follows. `hold_a_o` is 0 for T cycles (T from `track_cyc_i`), `hold_b_o` is 1, and the code is unchanged. The sample-and-hold on A therefore captures channel A's code.
- R4: After A's window there is exactly one freeze cycle with both holds at 1 and A's code still applied. B's code is applied only after that cycle.
- R5: Channel B follows the same pattern: B's code with both holds at 1 for S cycles, then `hold_b_o` at 0 for T cycles, then both holds return to 1.
- R6: `hold_a_o` and `hold_b_o` are never both 0.
- R7: `dac_code_o` changes only in a cycle where both holds are 1 and both were also 1 in the previous cycle.
- R8: After a schedule ends, the block idles for R+1 cycles, where R is `refresh_cyc_i`. It then reruns the full schedule with the latest codes, even if no new write has arrived.
- R9: A write made during a schedule does not change that schedule. The write makes the next schedule start right after the current one, with one idle cycle.
- R10: When several writes arrive before a schedule starts, the last write wins.
- R11: S, T and R are sampled when the phase they time begins. A value of 0 for S or T counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_wr_i | input | 1 | Capture `code_a_i`/`code_b_i` as the pending pair |
| code_a_i | input | CODE_W | Code for channel A |
| code_b_i | input | CODE_W | Code for channel B |
| settle_cyc_i | input | CNT_W | Settling wait in cycles |
| track_cyc_i | input | CNT_W | Track window in cycles |
| refresh_cyc_i | input | CNT_W | Idle cycles before a refresh, minus one |
| dac_code_o | output | CODE_W | Code to the converter |
| hold_a_o | output | 1 | Channel A hold control (1 = hold) |
| hold_b_o | output | 1 | Channel B hold control (1 = hold) |

## Verification
The assertions check the safety rules on every cycle:
- at most one track line is low at a time;
- the code moves only inside an all-hold interval;
- each track window opens on a stable code after an all-hold cycle;
- the freeze cycle comes before the code switches.

Some behaviour can only be shown by the bench scenarios, because it depends on history and timing:
- which code each stage captures;
- the exact settle and track lengths;
- the refresh period;
- how a write buffered mid-schedule is deferred;
- that the last of several writes wins;
- how a zero count is treated.

These are compared against a behavioural schedule model on every clock.

// File: rtl/dshm_pkg.sv
package dshm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_A_SET = 3'd1,
    ST_A_TRK = 3'd2,
    ST_A_FRZ = 3'd3,
    ST_B_SET = 3'd4,
    ST_B_TRK = 3'd5
  } seq_st_e;
endpackage

// File: rtl/dshm_code_buf.sv
module dshm_code_buf #(
  parameter int CODE_W = 12,
  parameter int N_CH   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [N_CH-1:0][CODE_W-1:0]  code_i,
  input  logic                         take_i,
  output logic [N_CH-1:0][CODE_W-1:0]  code_o,
  output logic                         pend_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   code_q <= '0;
      else if (wr_i) code_q <= code_i[c];
    end
    assign code_o[c] = code_q;
  end

  // a write in the take cycle stays pending for the following schedule
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= 1'b0;
    else if (wr_i)    pend_o <= 1'b1;
    else if (take_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/dshm_refresh_tmr.sv
module dshm_refresh_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             idle_i,
  output logic             due_o
);
  logic [CNT_W-1:0] left_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      left_q  <= period_i;
      armed_q <= 1'b1;
    end else if (idle_i && left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end
  end

  assign due_o = armed_q && (left_q == '0);
endmodule

// File: rtl/dshm_seq_fsm.sv
module dshm_seq_fsm
  import dshm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic [CNT_W-1:0] track_i,
  output seq_st_e          st_o,
  output logic             done_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  assign last = (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_A_SET;
          cnt_q <= at_least_one(settle_i);
        end
        ST_A_SET: if (last) begin
          st_q  <= ST_A_TRK;
          cnt_q <= at_least_one(track_i);
        end else cnt_q <= cnt_q - 1'b1;
        ST_A_TRK: if (last) st_q <= ST_A_FRZ;
                  else      cnt_q <= cnt_q - 1'b1;
        ST_A_FRZ: begin
          st_q  <= ST_B_SET;
          cnt_q <= at_least_one(settle_i);
        end
        ST_B_SET: if (last) begin
          st_q  <= ST_B_TRK;
          cnt_q <= at_least_one(track_i);
        end else cnt_q <= cnt_q - 1'b1;
        ST_B_TRK: if (last) st_q <= ST_IDLE;
                  else      cnt_q <= cnt_q - 1'b1;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign done_o = (st_q == ST_B_TRK) && last;
endmodule

// File: rtl/dac_sh_mux_ctrl.sv
module dac_sh_mux_ctrl
  import dshm_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_wr_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic [CNT_W-1:0]  settle_cyc_i,
  input  logic [CNT_W-1:0]  track_cyc_i,
  input  logic [CNT_W-1:0]  refresh_cyc_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              hold_a_o,
  output logic              hold_b_o
);
  localparam int N_CH = 2;

  logic [N_CH-1:0][CODE_W-1:0] wr_codes, buf_codes;
  logic        pend, due, start, done, idle;
  seq_st_e     st;
  logic [CODE_W-1:0] dac_q, b_code_q;

  assign wr_codes = {code_b_i, code_a_i};
  assign idle     = (st == ST_IDLE);
  assign start    = idle && (pend || due);

  dshm_code_buf #(.CODE_W(CODE_W), .N_CH(N_CH)) u_buf (
    .clk_i, .rst_ni,
    .wr_i   (code_wr_i),
    .code_i (wr_codes),
    .take_i (start),
    .code_o (buf_codes),
    .pend_o (pend)
  );

  dshm_refresh_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i   (done),
    .period_i (refresh_cyc_i),
    .idle_i   (idle),
    .due_o    (due)
  );

  dshm_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i  (start),
    .settle_i (settle_cyc_i),
    .track_i  (track_cyc_i),
    .st_o     (st),
    .done_o   (done)
  );

  // B's code is snapshotted at start so a later write cannot reach it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q    <= '0;
      b_code_q <= '0;
    end else if (start) begin
      dac_q    <= buf_codes[0];
      b_code_q <= buf_codes[1];
    end else if (st == ST_A_FRZ) begin
      dac_q    <= b_code_q;
    end
  end

  assign dac_code_o = dac_q;
  assign hold_a_o   = (st != ST_A_TRK);
  assign hold_b_o   = (st != ST_B_TRK);
endmodule

// File: rtl/dshm_checker.sv
module dshm_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              hold_a_o,
  input logic              hold_b_o
);
  a_r6_one_tracking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_a_o || hold_b_o);

  a_r7_code_moves_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_code_o) |-> hold_a_o && hold_b_o && $past(hold_a_o) && $past(hold_b_o));

  a_r3_track_code_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_a_o || !hold_b_o) |-> $stable(dac_code_o));

  a_r2_a_opens_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_a_o) |-> $past(hold_b_o) && $stable(dac_code_o));

  a_r5_b_opens_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_b_o) |-> $past(hold_a_o) && $stable(dac_code_o));

  a_r4_freeze_before_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_a_o) |-> hold_b_o && $stable(dac_code_o));
endmodule

bind dac_sh_mux_ctrl dshm_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dac_code_o (dac_code_o),
  .hold_a_o   (hold_a_o),
  .hold_b_o   (hold_b_o)
);

// File: tb/dac_sh_mux_ctrl_tb.sv
module dac_sh_mux_ctrl_tb;
  localparam int CW = 12;
  localparam int NW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [CW-1:0] ca = '0, cb = '0;
  logic [NW-1:0] settle = 16'd3, track = 16'd2, refresh = 16'd20;
  logic [CW-1:0] dac;
  logic ha, hb;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dac_sh_mux_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .code_wr_i(wr), .code_a_i(ca), .code_b_i(cb),
    .settle_cyc_i(settle), .track_cyc_i(track), .refresh_cyc_i(refresh),
    .dac_code_o(dac), .hold_a_o(ha), .hold_b_o(hb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural schedule model: phase 0 idle,1 A settle,2 A track,3 freeze,4 B settle,5 B track
  int m_ph, m_left, m_idle;
  bit m_seen, m_new;
  logic [CW-1:0] m_pa, m_pb, m_bsnap, m_dac;

  function automatic int floor1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_idle = 0; m_seen = 0; m_new = 0;
      m_pa = '0; m_pb = '0; m_bsnap = '0; m_dac = '0;
    end else begin
      case (m_ph)
        0: if (m_new || (m_seen && m_idle == 0)) begin
             m_ph = 1; m_left = floor1(int'(settle));
             m_dac = m_pa; m_bsnap = m_pb; m_new = 0;
           end else if (m_idle > 0) m_idle--;
        1, 4: if (m_left <= 1) begin m_ph++; m_left = floor1(int'(track)); end
              else m_left--;
        2: if (m_left <= 1) m_ph = 3; else m_left--;
        3: begin m_ph = 4; m_left = floor1(int'(settle)); m_dac = m_bsnap; end
        5: if (m_left <= 1) begin m_ph = 0; m_idle = int'(refresh); m_seen = 1; end
           else m_left--;
        default: m_ph = 0;
      endcase
      if (wr) begin m_pa = ca; m_pb = cb; m_new = 1; end
    end
  end

  // sample-and-hold model plus window measurement
  logic [CW-1:0] sh_a = '0, sh_b = '0;
  int sh_na = 0, sh_nb = 0, run_a = 0, run_b = 0, win_a = 0, win_b = 0;
  int rise_b = 0, gap_b = 0;
  logic pa_h = 1'b1, pb_h = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(dac == m_dac && ha == (m_ph != 2) && hb == (m_ph != 5),
          "R2 R3 R4 R5 R6 R7 per-cycle schedule",
          {dac, ha, hb}, {m_dac, m_ph != 2, m_ph != 5});
      if (!ha) run_a++;
      if (!hb) run_b++;
      if (!pa_h && ha) begin sh_a = dac; sh_na++; win_a = run_a; run_a = 0; end
      if (!pb_h && hb) begin
        sh_b = dac; sh_nb++; win_b = run_b; run_b = 0;
        gap_b = cyc - rise_b; rise_b = cyc;
      end
    end
    pa_h = ha; pb_h = hb;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic put(input logic [CW-1:0] a, input logic [CW-1:0] b);
    ca = a; cb = b; wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic wait_b(input int k);
    while (sh_nb < k) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    finish_run();
  end

  initial begin
    int seq_len;
    tick(3);
    chk(dac == 0 && ha && hb, "R1 reset state", {dac, ha, hb}, 3);
    rst_n = 1'b1;
    tick(8);
    chk(dac == 0 && ha && hb, "R1 idle before first write", {dac, ha, hb}, 3);

    put(12'h123, 12'hABC);
    wait_b(1);
    chk(sh_a == 12'h123, "R3 A captured", sh_a, 12'h123);
    chk(sh_b == 12'hABC, "R5 B captured", sh_b, 12'hABC);
    chk(win_a == 2, "R3 A window", win_a, 2);
    chk(win_b == 2, "R5 B window", win_b, 2);

    seq_len = 2 * (3 + 2) + 1;
    wait_b(2);
    chk(gap_b == seq_len + 21, "R8 refresh period", gap_b, seq_len + 21);
    chk(sh_a == 12'h123 && sh_b == 12'hABC, "R8 refresh reuses codes", {sh_a, sh_b}, {12'h123, 12'hABC});

    while (ha) tick();
    put(12'h555, 12'h0AA);
    put(12'hFFF, 12'h001);
    wait_b(3);
    chk(sh_a == 12'h123 && sh_b == 12'hABC, "R9 current schedule untouched", {sh_a, sh_b}, {12'h123, 12'hABC});
    wait_b(4);
    chk(gap_b == seq_len + 1, "R9 immediate follow-on", gap_b, seq_len + 1);
    chk(sh_a == 12'hFFF, "R10 last write A", sh_a, 12'hFFF);
    chk(sh_b == 12'h001, "R10 last write B", sh_b, 12'h001);

    settle = '0; track = '0; refresh = '0;
    put(12'h7E7, 12'h181);
    wait_b(sh_nb + 2);
    chk(win_a == 1 && win_b == 1, "R11 zero track counts as one", {win_a, win_b}, {1, 1});
    chk(sh_a == 12'h7E7 && sh_b == 12'h181, "R11 zero-count capture", {sh_a, sh_b}, {12'h7E7, 12'h181});
    wait_b(sh_nb + 1);
    chk(gap_b == 2 * (1 + 1) + 1 + 1, "R8 R11 zero refresh gap", gap_b, 6);
    tick(4);
    finish_run();
  end
endmodule